// File: doc/BRIEF.md
# Display Controller Register File

This block is the software-visible configuration and status store of a raster display controller. A simple 32-bit bus reads and writes six word registers at byte offsets 0x00 to 0x14: a control word, three timing words, a status word and a subpanel word. The stored fields go straight to the display datapath: the enable, the monochrome select, the panel-type select, the load mode, the active width and height, and the subpanel setup.

The datapath reports three events back as single-cycle set pulses: frame done, sync error and palette done. Each pulse sets a sticky status flag, and software clears a flag by writing a one to its bit. A single level interrupt combines the flags with two mask bits from the control word. A sync error asserts the interrupt whatever the masks hold.

Several read paths return constant ones in fixed bit positions. The width and height fields hold the pixel count minus one. The block widens those fields by one before it exports them.

Top module: `dcr_regfile`

## Requirements
- R1: A write to offset 0x00 stores enable from bit 0, mono from bit 1, the interrupt mask from bits 4:3, panel type from bit 7 and the load mode from bits 21:20. These values appear on the ctl_* outputs in the cycle after the write edge.
- R2: A read of offset 0x00 returns the bits of the last write that fall under mask 0x01CFF300, ORed with the constant 0xFE000C34. The fields of R1 are ORed in at their bit positions, and the panel-type bit is also copied into bit 23.
- R3: A write to offset 0x04 stores the full word. ctl_width equals bits 9:0 of that word plus one. A read of 0x04 returns the stored word with bits 3:0 forced to one.
- R4: A write to offset 0x08 stores the full word. ctl_height equals bits 9:0 of that word plus one. A read of 0x08 returns the stored word unchanged.
- R5: A write to offset 0x0C stores the full word. A read of 0x0C returns it with bits 31:26 forced to one.
- R6: Offset 0x10 reads the status flags: frame done in bit 0, sync error in bit 2 and palette done in bit 6. All other bits read zero. A pulse on set_frame_done, set_sync_err or set_palette_done sets the matching flag at the next clock edge.
- R7: A write to 0x10 clears each flag whose bit is one in the written word and leaves the other flags unchanged. If a set pulse and a clear of the same flag occur in the same cycle, the flag ends set.
- R8: A write to offset 0x14 stores the written word ANDed with 0xA1FFFFFF. A read of 0x14 and ctl_subpanel both return that stored value.
- R9: irq is high when frame done is set and control bit 3 is one, or when palette done is set and control bit 4 is one.
- R10: irq is high whenever sync error is set, whatever the mask bits hold. irq is low in every case not covered by R9 or R10.
- R11: After reset every stored bit is zero. The reads then give 0xFE000C34, 0x0000000F, 0x00000000, 0xFC000000, 0x00000000 and 0x00000000 for offsets 0x00 to 0x14. ctl_width and ctl_height read 1, and irq is low.
- R12: bus_rdata holds the addressed word from the clock edge at which bus_rd is sampled high. Reads of unmapped or unaligned offsets return zero. Writes to those offsets change no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| set_frame_done | input | 1 | Pulse that sets the frame-done flag |
| set_sync_err | input | 1 | Pulse that sets the sync-error flag |
| set_palette_done | input | 1 | Pulse that sets the palette-done flag |
| irq | output | 1 | Level interrupt |
| ctl_enable | output | 1 | Controller enable |
| ctl_mono | output | 1 | Monochrome select |
| ctl_panel_type | output | 1 | Panel-type select |
| ctl_load_mode | output | 2 | Palette and data load mode |
| ctl_width | output | 11 | Active width in pixels |
| ctl_height | output | 11 | Active height in lines |
| ctl_subpanel | output | 32 | Stored subpanel setup |

## Verification
A write changes a register, and therefore every ctl_* output, at the sampling edge. Read data appears at the edge that samples bus_rd. A set pulse or a status clear takes effect at its edge, and irq follows through combinational logic with no further delay. Every bench task drives inputs on a falling edge and holds them for one full cycle. It samples outputs on the next falling edge, which is half a cycle after the edge that updates them, so each check looks at the value produced by exactly one edge.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

   localparam int unsigned REG_W    = 32;
   localparam int unsigned DIM_W    = 10;
   localparam int unsigned NUM_REGS = 6;

   typedef enum logic [2:0] {
      IDX_CTRL = 3'd0,
      IDX_TIM0 = 3'd1,
      IDX_TIM1 = 3'd2,
      IDX_TIM2 = 3'd3,
      IDX_STAT = 3'd4,
      IDX_SUBP = 3'd5
   } reg_idx_e;

   // control field positions
   localparam int unsigned CTL_EN_BIT     = 0;
   localparam int unsigned CTL_MONO_BIT   = 1;
   localparam int unsigned CTL_MASK_LO    = 3;
   localparam int unsigned CTL_PANEL_BIT  = 7;
   localparam int unsigned CTL_LOAD_LO    = 20;
   localparam int unsigned CTL_MIRROR_BIT = 23;

   // status flag positions
   localparam int unsigned ST_FRAME_BIT = 0;
   localparam int unsigned ST_SYNC_BIT  = 2;
   localparam int unsigned ST_PAL_BIT   = 6;

   localparam logic [REG_W-1:0] CTRL_KEEP_MASK  = 32'h01CF_F300;
   localparam logic [REG_W-1:0] CTRL_READ_ONES  = 32'hFE00_0C34;
   localparam logic [REG_W-1:0] SUBP_WRITE_MASK = 32'hA1FF_FFFF;

   // forced-one patterns of the three timing words, by index
   localparam logic [3*REG_W-1:0] TIM_READ_ONES =
      {32'hFC00_0000, 32'h0000_0000, 32'h0000_000F};

   typedef struct packed {
      logic             enable;
      logic             mono;
      logic [1:0]       irq_mask;
      logic             panel;
      logic [1:0]       load_mode;
      logic [REG_W-1:0] keep;
   } ctrl_t;

endpackage

// File: rtl/dcr_addr_dec.sv
module dcr_addr_dec #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned N_REGS = 6
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [N_REGS-1:0] sel
);
   localparam int unsigned MAX_OFS = (N_REGS - 1) * 4;

   if (MAX_OFS >= (1 << ADDR_W)) begin : g_bad_addr_w
      $error("dcr_addr_dec: ADDR_W too narrow for the register count");
   end

   for (genvar i = 0; i < N_REGS; i++) begin : g_sel
      localparam logic [ADDR_W-1:0] OFS = ADDR_W'(i * 4);
      assign sel[i] = (addr == OFS);
   end
endmodule

// File: rtl/dcr_cfg_regs.sv
module dcr_cfg_regs
   import dcr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   input  logic             sel_ctrl,
   input  logic [2:0]       sel_tim,
   input  logic             sel_subp,
   output ctrl_t            ctrl_q,
   output logic [REG_W-1:0] tim_q [3],
   output logic [REG_W-1:0] subp_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr && sel_ctrl) begin
         ctrl_q.enable    <= wdata[CTL_EN_BIT];
         ctrl_q.mono      <= wdata[CTL_MONO_BIT];
         ctrl_q.irq_mask  <= wdata[CTL_MASK_LO +: 2];
         ctrl_q.panel     <= wdata[CTL_PANEL_BIT];
         ctrl_q.load_mode <= wdata[CTL_LOAD_LO +: 2];
         ctrl_q.keep      <= wdata & CTRL_KEEP_MASK;
      end
   end

   for (genvar k = 0; k < 3; k++) begin : g_tim
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tim_q[k] <= '0;
         end else if (wr && sel_tim[k]) begin
            tim_q[k] <= wdata;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         subp_q <= '0;
      end else if (wr && sel_subp) begin
         subp_q <= wdata & SUBP_WRITE_MASK;
      end
   end
endmodule

// File: rtl/dcr_status_irq.sv
module dcr_status_irq
   import dcr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_frame,
   input  logic             set_sync,
   input  logic             set_pal,
   input  logic             clr_en,
   input  logic [REG_W-1:0] clr_bits,
   input  logic [1:0]       irq_mask,
   output logic [REG_W-1:0] status_word,
   output logic             irq
);
   localparam int unsigned NF = 3;
   localparam int unsigned FLAG_POS [NF] = '{ST_FRAME_BIT, ST_SYNC_BIT, ST_PAL_BIT};

   logic [NF-1:0] set_vec;
   logic [NF-1:0] flag_q;

   assign set_vec = {set_pal, set_sync, set_frame};

   for (genvar f = 0; f < NF; f++) begin : g_flag
      logic clr_this;
      assign clr_this = clr_en && clr_bits[FLAG_POS[f]];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flag_q[f] <= 1'b0;
         end else if (set_vec[f]) begin
            flag_q[f] <= 1'b1;
         end else if (clr_this) begin
            flag_q[f] <= 1'b0;
         end
      end
   end

   always_comb begin
      status_word               = '0;
      status_word[ST_FRAME_BIT] = flag_q[0];
      status_word[ST_SYNC_BIT]  = flag_q[1];
      status_word[ST_PAL_BIT]   = flag_q[2];
   end

   assign irq = (flag_q[0] && irq_mask[0]) ||
                (flag_q[2] && irq_mask[1]) ||
                flag_q[1];
endmodule

// File: rtl/dcr_readback.sv
module dcr_readback
   import dcr_pkg::*;
#(
   parameter int unsigned N_REGS     = 6,
   parameter bit          RDATA_FLOP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd,
   input  logic [N_REGS-1:0] sel,
   input  logic [REG_W-1:0] words [N_REGS],
   output logic [REG_W-1:0] rdata
);
   logic [REG_W-1:0] mux_w;

   always_comb begin
      mux_w = '0;
      for (int i = 0; i < N_REGS; i++) begin
         if (sel[i]) mux_w = mux_w | words[i];
      end
   end

   if (RDATA_FLOP) begin : g_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rdata <= '0;
         end else if (rd) begin
            rdata <= mux_w;
         end
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n ^ rd;
      assign rdata = mux_w;
   end
endmodule

// File: rtl/dcr_regfile.sv
module dcr_regfile
   import dcr_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter bit          RDATA_FLOP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              set_frame_done,
   input  logic              set_sync_err,
   input  logic              set_palette_done,
   output logic              irq,
   output logic              ctl_enable,
   output logic              ctl_mono,
   output logic              ctl_panel_type,
   output logic [1:0]        ctl_load_mode,
   output logic [DIM_W:0]    ctl_width,
   output logic [DIM_W:0]    ctl_height,
   output logic [31:0]       ctl_subpanel
);
   if (REG_W != 32) begin : g_bad_reg_w
      $error("dcr_regfile: register width must be 32");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("dcr_regfile: ADDR_W must cover offset 0x14");
   end

   logic [NUM_REGS-1:0] sel;
   ctrl_t               ctrl_q;
   logic [REG_W-1:0]    tim_q [3];
   logic [REG_W-1:0]    subp_q;
   logic [REG_W-1:0]    status_word;
   logic [REG_W-1:0]    words [NUM_REGS];
   logic [REG_W-1:0]    ctrl_rd;

   dcr_addr_dec #(.ADDR_W(ADDR_W), .N_REGS(NUM_REGS)) u_dec (
      .addr (bus_addr),
      .sel  (sel)
   );

   dcr_cfg_regs u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (bus_wr),
      .wdata    (bus_wdata),
      .sel_ctrl (sel[IDX_CTRL]),
      .sel_tim  (sel[IDX_TIM2:IDX_TIM0]),
      .sel_subp (sel[IDX_SUBP]),
      .ctrl_q   (ctrl_q),
      .tim_q    (tim_q),
      .subp_q   (subp_q)
   );

   dcr_status_irq u_stat (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_frame   (set_frame_done),
      .set_sync    (set_sync_err),
      .set_pal     (set_palette_done),
      .clr_en      (bus_wr && sel[IDX_STAT]),
      .clr_bits    (bus_wdata),
      .irq_mask    (ctrl_q.irq_mask),
      .status_word (status_word),
      .irq         (irq)
   );

   always_comb begin
      ctrl_rd = ctrl_q.keep | CTRL_READ_ONES;
      ctrl_rd[CTL_EN_BIT]        = ctrl_rd[CTL_EN_BIT]   | ctrl_q.enable;
      ctrl_rd[CTL_MONO_BIT]      = ctrl_rd[CTL_MONO_BIT] | ctrl_q.mono;
      ctrl_rd[CTL_MASK_LO +: 2]  = ctrl_rd[CTL_MASK_LO +: 2] | ctrl_q.irq_mask;
      ctrl_rd[CTL_PANEL_BIT]     = ctrl_rd[CTL_PANEL_BIT]  | ctrl_q.panel;
      ctrl_rd[CTL_MIRROR_BIT]    = ctrl_rd[CTL_MIRROR_BIT] | ctrl_q.panel;
      ctrl_rd[CTL_LOAD_LO +: 2]  = ctrl_rd[CTL_LOAD_LO +: 2] | ctrl_q.load_mode;
   end

   assign words[IDX_CTRL] = ctrl_rd;
   for (genvar k = 0; k < 3; k++) begin : g_tim_rd
      assign words[IDX_TIM0 + k] = tim_q[k] | TIM_READ_ONES[k*REG_W +: REG_W];
   end
   assign words[IDX_STAT] = status_word;
   assign words[IDX_SUBP] = subp_q;

   dcr_readback #(.N_REGS(NUM_REGS), .RDATA_FLOP(RDATA_FLOP)) u_rb (
      .clk   (clk),
      .rst_n (rst_n),
      .rd    (bus_rd),
      .sel   (sel),
      .words (words),
      .rdata (bus_rdata)
   );

   assign ctl_enable     = ctrl_q.enable;
   assign ctl_mono       = ctrl_q.mono;
   assign ctl_panel_type = ctrl_q.panel;
   assign ctl_load_mode  = ctrl_q.load_mode;
   assign ctl_width      = {1'b0, tim_q[0][DIM_W-1:0]} + 1'b1;
   assign ctl_height     = {1'b0, tim_q[1][DIM_W-1:0]} + 1'b1;
   assign ctl_subpanel   = subp_q;
endmodule

// File: rtl/dcr_regfile_chk.sv
module dcr_regfile_chk
   import dcr_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic              set_frame_done,
   input logic              set_sync_err,
   input logic              set_palette_done,
   input logic              irq,
   input logic              ctl_enable,
   input logic              ctl_mono,
   input logic              ctl_panel_type,
   input logic [1:0]        ctl_load_mode,
   input logic [DIM_W:0]    ctl_width,
   input logic [DIM_W:0]    ctl_height,
   input logic [31:0]       ctl_subpanel
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_TIM0 = ADDR_W'(4);
   localparam logic [ADDR_W-1:0] A_TIM1 = ADDR_W'(8);
   localparam logic [ADDR_W-1:0] A_SUBP = ADDR_W'(20);

   logic unused_in;
   assign unused_in = bus_rd ^ ctl_mono ^ (^bus_rdata);

   // R1
   ctrl_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_CTRL) |=>
         (ctl_enable == $past(bus_wdata[0]) &&
          ctl_panel_type == $past(bus_wdata[7]) &&
          ctl_load_mode == $past(bus_wdata[21:20])));

   // R3
   width_plus_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_TIM0) |=>
         (ctl_width == ({1'b0, $past(bus_wdata[9:0])} + 11'd1)));

   // R4
   height_plus_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_TIM1) |=>
         (ctl_height == ({1'b0, $past(bus_wdata[9:0])} + 11'd1)));

   // R8
   subpanel_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_SUBP) |=>
         (ctl_subpanel == ($past(bus_wdata) & 32'hA1FF_FFFF)));

   // R10
   sync_forces_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_sync_err |=> irq);

   // R9
   irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(set_frame_done || set_palette_done || set_sync_err ||
                           (bus_wr && bus_addr == A_CTRL)));

   // R12
   no_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> ($stable(ctl_subpanel) && $stable(ctl_width) &&
                   $stable(ctl_height) && $stable(ctl_enable)));
endmodule

bind dcr_regfile dcr_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_dcr_regfile.sv
module sim_dcr_regfile;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        set_frame_done = 1'b0;
   logic        set_sync_err = 1'b0;
   logic        set_palette_done = 1'b0;
   logic        irq;
   logic        ctl_enable, ctl_mono, ctl_panel_type;
   logic [1:0]  ctl_load_mode;
   logic [10:0] ctl_width, ctl_height;
   logic [31:0] ctl_subpanel;

   int n_cmp = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   dcr_regfile u0 (.*);

   function automatic logic [31:0] ctrl_model(input logic [31:0] w);
      logic [31:0] r;
      r = (w & 32'h01CF_F300) | 32'hFE00_0C34 | (w & 32'h0030_009B);
      r[23] = r[23] | w[7];
      return r;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic pulse(input logic f, input logic s, input logic p);
      @(negedge clk);
      set_frame_done = f; set_sync_err = s; set_palette_done = p;
      @(negedge clk);
      set_frame_done = 1'b0; set_sync_err = 1'b0; set_palette_done = 1'b0;
   endtask

   task automatic t_reset_values();
      logic [31:0] d;
      chk("R11 irq", {31'd0, irq}, 32'd0);
      chk("R11 width", {21'd0, ctl_width}, 32'd1);
      chk("R11 height", {21'd0, ctl_height}, 32'd1);
      rd(8'h00, d); chk("R11 ctrl", d, 32'hFE00_0C34);
      rd(8'h04, d); chk("R11 tim0", d, 32'h0000_000F);
      rd(8'h08, d); chk("R11 tim1", d, 32'h0);
      rd(8'h0C, d); chk("R11 tim2", d, 32'hFC00_0000);
      rd(8'h10, d); chk("R11 status", d, 32'h0);
      rd(8'h14, d); chk("R11 subpanel", d, 32'h0);
   endtask

   task automatic t_control();
      logic [31:0] d;
      wr(8'h00, 32'hFFFF_FFFF);
      chk("R1 enable", {31'd0, ctl_enable}, 32'd1);
      chk("R1 load", {30'd0, ctl_load_mode}, 32'd3);
      rd(8'h00, d); chk("R2 ctrl all ones", d, 32'hFFFF_FFBF);
      wr(8'h00, 32'h0000_0081);
      chk("R1 panel", {31'd0, ctl_panel_type}, 32'd1);
      chk("R1 mono", {31'd0, ctl_mono}, 32'd0);
      rd(8'h00, d); chk("R2 ctrl mirror", d, 32'hFE80_0CB5);
      wr(8'h00, 32'h0012_3456);
      chk("R1 load mode 1", {30'd0, ctl_load_mode}, 32'd1);
      chk("R1 mono set", {31'd0, ctl_mono}, 32'd1);
      rd(8'h00, d); chk("R2 ctrl pattern", d, ctrl_model(32'h0012_3456));
      wr(8'h00, 32'h0);
   endtask

   task automatic t_timing();
      logic [31:0] d;
      wr(8'h04, 32'h1234_5670);
      chk("R3 width", {21'd0, ctl_width}, 32'd625);
      rd(8'h04, d); chk("R3 tim0 read", d, 32'h1234_567F);
      wr(8'h04, 32'h0000_03FF);
      chk("R3 width max", {21'd0, ctl_width}, 32'd1024);
      wr(8'h08, 32'h8765_4321);
      chk("R4 height", {21'd0, ctl_height}, 32'h322);
      rd(8'h08, d); chk("R4 tim1 read", d, 32'h8765_4321);
      wr(8'h0C, 32'h0000_1234);
      rd(8'h0C, d); chk("R5 tim2 read", d, 32'hFC00_1234);
   endtask

   task automatic t_subpanel();
      logic [31:0] d;
      wr(8'h14, 32'hFFFF_FFFF);
      chk("R8 export", ctl_subpanel, 32'hA1FF_FFFF);
      rd(8'h14, d); chk("R8 read", d, 32'hA1FF_FFFF);
   endtask

   task automatic t_status();
      logic [31:0] d;
      wr(8'h00, 32'h0);
      pulse(1'b1, 1'b0, 1'b0);
      chk("R9 frame masked irq", {31'd0, irq}, 32'd0);
      rd(8'h10, d); chk("R6 frame flag", d, 32'h1);
      pulse(1'b0, 1'b0, 1'b1);
      rd(8'h10, d); chk("R6 palette flag", d, 32'h41);
      wr(8'h10, 32'h1);
      rd(8'h10, d); chk("R7 clear frame only", d, 32'h40);
      // set and clear of frame done in the same cycle: set wins
      @(negedge clk);
      set_frame_done = 1'b1; bus_wr = 1'b1; bus_addr = 8'h10; bus_wdata = 32'h1;
      @(negedge clk);
      set_frame_done = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
      rd(8'h10, d); chk("R7 set beats clear", d, 32'h41);
      wr(8'h10, 32'hFFFF_FFFF);
      rd(8'h10, d); chk("R7 clear all", d, 32'h0);
   endtask

   task automatic t_irq();
      logic [31:0] d;
      wr(8'h00, 32'h0000_0008);
      pulse(1'b1, 1'b0, 1'b0);
      chk("R9 frame irq", {31'd0, irq}, 32'd1);
      wr(8'h10, 32'h1);
      chk("R10 irq low after clear", {31'd0, irq}, 32'd0);
      pulse(1'b0, 1'b0, 1'b1);
      chk("R9 palette masked by bit4", {31'd0, irq}, 32'd0);
      wr(8'h00, 32'h0000_0010);
      chk("R9 palette irq on mask enable", {31'd0, irq}, 32'd1);
      wr(8'h10, 32'h40);
      wr(8'h00, 32'h0);
      pulse(1'b0, 1'b1, 1'b0);
      chk("R10 sync irq no mask", {31'd0, irq}, 32'd1);
      rd(8'h10, d); chk("R6 sync flag", d, 32'h4);
      wr(8'h10, 32'h4);
      chk("R10 sync cleared", {31'd0, irq}, 32'd0);
   endtask

   task automatic t_unmapped();
      logic [31:0] d;
      wr(8'h00, 32'h0000_0001);
      wr(8'h18, 32'hFFFF_FFFF);
      wr(8'h02, 32'hFFFF_FFFF);
      rd(8'h18, d); chk("R12 unmapped read", d, 32'h0);
      rd(8'h02, d); chk("R12 unaligned read", d, 32'h0);
      rd(8'h00, d); chk("R12 ctrl untouched", d, ctrl_model(32'h1));
      chk("R12 subpanel untouched", ctl_subpanel, 32'hA1FF_FFFF);
      chk("R12 height untouched", {21'd0, ctl_height}, 32'h322);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_values();
      t_control();
      t_timing();
      t_subpanel();
      t_status();
      t_irq();
      t_unmapped();
      repeat (2) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule